// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block sits between a PWM modulator and the two gate drivers of a synchronous buck stage. It turns the modulator's on/off request into a high-side and a low-side gate command that are never high together. Dead time is adaptive. When one gate is switched off, the other gate is held back until a comparator flag reports that the falling gate has crossed its turn-off threshold. A fixed delay then follows. A timeout lets the sequence continue if a flag never arrives.

The sequencer also handles light load. A zero-current flag switches the low side off so that inductor current cannot reverse, which gives discontinuous conduction. It counts high-side on-time against a maximum duty limit. It raises a skip indicator for one switching period after a period in which the modulator asked for no on-time. A fault sequencer drives two inputs: an enable that parks both gates low, and a force input that holds the low side on.

Top module: `nov_gate_ctrl`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both 1 in the same cycle.
- R2: After `ls_gate` falls, `hs_gate` may rise only once `ls_low_flag` has been sampled high in a wait cycle, followed by DEAD_CYC more cycles. If the flag is already high, both gates are low for exactly DEAD_CYC+1 cycles.
- R3: After `hs_gate` falls, `ls_gate` may rise only once `hs_low_flag` has been sampled high, followed by DEAD_CYC cycles. The cycle count is the same as in R2.
- R4: If the awaited off flag stays low, the wait ends after WAIT_TMO_CYC cycles and the DEAD_CYC delay follows.
- R5: `hs_gate` stays high for at most MAX_ON = PERIOD_CYC*MAX_DUTY_PCT/100 cycles per pulse. After a capped pulse it does not rise again until the next period boundary.
- R6: While `ls_gate` is 1, `zero_cur` is 1, `force_ls` is 0 and no high-side request is pending, `ls_gate` drops at the next edge. Both gates then stay low until the next high-side request.
- R7: At each period boundary (every PERIOD_CYC cycles after enable), `skip_ind` becomes 1 if `pwm_req` was 0 throughout the period just ended, and 0 otherwise. It holds that value for the whole next period.
- R8: While `en` is 0, both gate commands and `skip_ind` are 0 one edge later, and the period count restarts from zero.
- R9: While `force_ls` is 1, the high side is turned off, the low side is brought on through the R3 sequence, and `zero_cur` is ignored.
- R10: After synchronous reset, `hs_gate`, `ls_gate` and `skip_ind` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable from the fault sequencer |
| force_ls | input | 1 | Hold low side on, block high side |
| pwm_req | input | 1 | High-side on request from the modulator |
| hs_low_flag | input | 1 | High-side gate-to-phase voltage is below the off threshold |
| ls_low_flag | input | 1 | Low-side gate voltage is below the off threshold |
| zero_cur | input | 1 | Inductor current has reached zero |
| hs_gate | output | 1 | High-side gate command (registered) |
| ls_gate | output | 1 | Low-side gate command (registered) |
| skip_ind | output | 1 | Previous period had no on-time request |

## Verification
Every output is registered. A change of `pwm_req`, `force_ls`, `zero_cur` or `en` affects the gates at the first rising edge after the change. A gate flag sampled in a wait cycle starts the DEAD_CYC countdown at that edge. The skip indicator changes only on the edge that closes a period. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares all three outputs against that model on the next falling edge, so each expected value is tested in exactly the cycle it is due. The gate feedback flags come from a bench model of the drivers that reports a gate as low a fixed number of cycles after its command falls. A stuck-flag mode in that model exercises the timeout.

// File: rtl/nov_pkg.sv
package nov_pkg;
  typedef enum logic [2:0] {
    NS_IDLE,
    NS_WAIT_LO,
    NS_DEAD_HI,
    NS_HS_ON,
    NS_WAIT_HI,
    NS_DEAD_LO,
    NS_LS_ON
  } nov_state_e;
endpackage

// File: rtl/nov_period_track.sv
module nov_period_track #(
  parameter int PERIOD_CYC = 833
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pwm_req,
  output logic wrap,
  output logic skip_ind
);
  localparam int PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD_CYC - 1);

  logic [PW-1:0] pcnt;
  logic          seen;

  assign wrap = (pcnt == P_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pcnt     <= '0;
      seen     <= 1'b0;
      skip_ind <= 1'b0;
    end else if (wrap) begin
      pcnt     <= '0;
      seen     <= 1'b0;
      skip_ind <= !(seen || pwm_req);
    end else begin
      pcnt <= pcnt + 1'b1;
      seen <= seen || pwm_req;
    end
  end
endmodule

// File: rtl/nov_ontime.sv
module nov_ontime #(
  parameter int MAX_ON = 749
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wrap,
  input  logic hs_next,
  output logic room
);
  localparam int OW = $clog2(MAX_ON + 1);
  localparam logic [OW-1:0] ON_LIM = OW'(MAX_ON);

  logic [OW-1:0] ontm;

  assign room = (ontm < ON_LIM);

  always_ff @(posedge clk) begin
    if (rst || !en) ontm <= '0;
    else if (hs_next) ontm <= ontm + 1'b1;
    else if (wrap) ontm <= '0;
  end
endmodule

// File: rtl/nov_seq.sv
module nov_seq
  import nov_pkg::*;
#(
  parameter int DEAD_CYC     = 8,
  parameter int WAIT_TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic force_ls,
  input  logic pwm_req,
  input  logic room,
  input  logic hs_low_flag,
  input  logic ls_low_flag,
  input  logic zero_cur,
  output logic hs_gate,
  output logic ls_gate,
  output logic hs_next
);
  localparam int TMAX = (WAIT_TMO_CYC > DEAD_CYC) ? WAIT_TMO_CYC : DEAD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_DEAD = TW'(DEAD_CYC - 1);
  localparam logic [TW-1:0] T_TMO  = TW'(WAIT_TMO_CYC - 1);

  nov_state_e st, st_n;
  logic [TW-1:0] tmr;
  logic want_hs, timed, wait_st;

  assign want_hs = pwm_req && !force_ls && room;
  assign wait_st = (st == NS_WAIT_LO) || (st == NS_DEAD_HI) ||
                   (st == NS_WAIT_HI) || (st == NS_DEAD_LO);
  assign timed   = (tmr == T_TMO);
  assign hs_next = (st_n == NS_HS_ON);

  always_comb begin
    st_n = st;
    unique case (st)
      NS_IDLE:    if (want_hs) st_n = NS_WAIT_LO;
                  else if (force_ls) st_n = NS_WAIT_HI;
      NS_WAIT_LO: if (!want_hs) st_n = NS_IDLE;
                  else if (ls_low_flag || timed) st_n = NS_DEAD_HI;
      NS_DEAD_HI: if (!want_hs) st_n = NS_IDLE;
                  else if (tmr == T_DEAD) st_n = NS_HS_ON;
      NS_HS_ON:   if (!want_hs) st_n = NS_WAIT_HI;
      NS_WAIT_HI: if (hs_low_flag || timed) st_n = NS_DEAD_LO;
      NS_DEAD_LO: if (tmr == T_DEAD) st_n = NS_LS_ON;
      NS_LS_ON:   if (want_hs) st_n = NS_WAIT_LO;
                  else if (zero_cur && !force_ls) st_n = NS_IDLE;
      default:    st_n = NS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st      <= NS_IDLE;
      tmr     <= '0;
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
    end else begin
      st      <= st_n;
      tmr     <= (wait_st && st_n == st) ? tmr + 1'b1 : '0;
      hs_gate <= (st_n == NS_HS_ON);
      ls_gate <= (st_n == NS_LS_ON);
    end
  end
endmodule

// File: rtl/nov_gate_ctrl.sv
module nov_gate_ctrl #(
  parameter int PERIOD_CYC   = 833,
  parameter int MAX_DUTY_PCT = 90,
  parameter int DEAD_CYC     = 8,
  parameter int WAIT_TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic force_ls,
  input  logic pwm_req,
  input  logic hs_low_flag,
  input  logic ls_low_flag,
  input  logic zero_cur,
  output logic hs_gate,
  output logic ls_gate,
  output logic skip_ind
);
  localparam int MAX_ON = (PERIOD_CYC * MAX_DUTY_PCT) / 100;

  logic wrap, room, hs_next;

  nov_period_track #(.PERIOD_CYC(PERIOD_CYC)) u_period (
    .clk(clk), .rst(rst), .en(en), .pwm_req(pwm_req),
    .wrap(wrap), .skip_ind(skip_ind)
  );

  nov_ontime #(.MAX_ON(MAX_ON)) u_ontime (
    .clk(clk), .rst(rst), .en(en), .wrap(wrap),
    .hs_next(hs_next), .room(room)
  );

  nov_seq #(.DEAD_CYC(DEAD_CYC), .WAIT_TMO_CYC(WAIT_TMO_CYC)) u_seq (
    .clk(clk), .rst(rst), .en(en), .force_ls(force_ls),
    .pwm_req(pwm_req), .room(room),
    .hs_low_flag(hs_low_flag), .ls_low_flag(ls_low_flag),
    .zero_cur(zero_cur),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .hs_next(hs_next)
  );
endmodule

// File: rtl/nov_gate_chk.sv
module nov_gate_chk #(
  parameter int MAX_ON = 749
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic force_ls,
  input logic zero_cur,
  input logic pwm_req,
  input logic hs_gate,
  input logic ls_gate,
  input logic skip_ind
);
  int unsigned run;

  always_ff @(posedge clk) begin
    if (rst) run <= 0;
    else run <= hs_gate ? run + 1 : 0;
  end

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  a_r2_hs_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> (!$past(ls_gate) && !$past(ls_gate, 2)));

  a_r3_ls_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> (!$past(hs_gate) && !$past(hs_gate, 2)));

  a_r5_on_limit: assert property (@(posedge clk) disable iff (rst)
    run <= MAX_ON);

  a_r6_zero_cut: assert property (@(posedge clk) disable iff (rst)
    (ls_gate && zero_cur && !force_ls && !pwm_req) |=> !ls_gate);

  a_r8_disable: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_gate && !ls_gate && !skip_ind));

  a_r9_force_hs_off: assert property (@(posedge clk) disable iff (rst)
    (force_ls && hs_gate) |=> !hs_gate);
endmodule

bind nov_gate_ctrl nov_gate_chk #(.MAX_ON(MAX_ON)) u_chk (
  .clk(clk), .rst(rst), .en(en), .force_ls(force_ls),
  .zero_cur(zero_cur), .pwm_req(pwm_req),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .skip_ind(skip_ind)
);

// File: tb/nov_gate_ctrl_tb.sv
`timescale 1ns/1ps
module nov_gate_ctrl_tb;
  localparam int PER    = 40;
  localparam int DUTY   = 90;
  localparam int DEAD   = 3;
  localparam int TMO    = 6;
  localparam int MAXON  = PER * DUTY / 100;
  localparam int FB_DLY = 2;

  logic clk = 0, rst = 1, en = 0, force_ls = 0, pwm_req = 0;
  logic hs_low_flag = 1, ls_low_flag = 1, zero_cur = 0;
  logic hs_gate, ls_gate, skip_ind;

  always #2 clk = ~clk;

  nov_gate_ctrl #(.PERIOD_CYC(PER), .MAX_DUTY_PCT(DUTY), .DEAD_CYC(DEAD),
                  .WAIT_TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .en(en), .force_ls(force_ls), .pwm_req(pwm_req),
    .hs_low_flag(hs_low_flag), .ls_low_flag(ls_low_flag), .zero_cur(zero_cur),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .skip_ind(skip_ind)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  bit compare_on = 0, stuck = 0, finished = 0;
  int hcnt = 0, lcnt = 0, hrun = 0;

  // reference model: phases 0 idle,1 await low-side off,2 delay before high,
  // 3 high on,4 await high-side off,5 delay before low,6 low on
  int mph = 0, mt = 0, mpc = 0, mon = 0;
  bit mseen = 0, mskip = 0;

  always @(posedge clk) begin
    if (rst || !en) begin
      mph = 0; mt = 0; mpc = 0; mon = 0; mseen = 0; mskip = 0;
    end else begin
      bit wh, wrap; int nx;
      wh = pwm_req && !force_ls && (mon < MAXON);
      nx = mph;
      if (mph == 0) begin if (wh) nx = 1; else if (force_ls) nx = 4; end
      else if (mph == 1) begin if (!wh) nx = 0; else if (ls_low_flag || mt == TMO-1) nx = 2; end
      else if (mph == 2) begin if (!wh) nx = 0; else if (mt == DEAD-1) nx = 3; end
      else if (mph == 3) begin if (!wh) nx = 4; end
      else if (mph == 4) begin if (hs_low_flag || mt == TMO-1) nx = 5; end
      else if (mph == 5) begin if (mt == DEAD-1) nx = 6; end
      else begin if (wh) nx = 1; else if (zero_cur && !force_ls) nx = 0; end
      mt = (nx == mph && mph != 0 && mph != 3 && mph != 6) ? mt + 1 : 0;
      wrap = (mpc == PER-1);
      if (nx == 3) mon = mon + 1; else if (wrap) mon = 0;
      if (wrap) begin mskip = !(mseen || pwm_req); mseen = 0; mpc = 0; end
      else begin mseen = mseen || pwm_req; mpc = mpc + 1; end
      mph = nx;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // output compare and driver-feedback emulation, away from the rising edge
  always @(negedge clk) begin
    if (compare_on) begin
      check(cur_req, "hs_gate", hs_gate, (mph == 3));
      check(cur_req, "ls_gate", ls_gate, (mph == 6));
      check(cur_req, "skip_ind", skip_ind, mskip);
      check("R1", "overlap", hs_gate && ls_gate, 0);
      hrun = hs_gate ? hrun + 1 : 0;
      if (hrun > MAXON) check("R5", "on-run", hrun, MAXON);
    end
    hcnt = hs_gate ? 0 : hcnt + 1;
    lcnt = ls_gate ? 0 : lcnt + 1;
    hs_low_flag = !stuck && (hcnt >= FB_DLY);
    ls_low_flag = !stuck && (lcnt >= FB_DLY);
  end

  task automatic run(input int n, input int on_len, input int zc_from);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwm_req  = ((i % PER) < on_len);
      zero_cur = ((i % PER) >= zc_from);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10", "hs_gate after reset", hs_gate, 0);
    check("R10", "ls_gate after reset", ls_gate, 0);
    check("R10", "skip after reset", skip_ind, 0);
    en = 1; compare_on = 1;
    cur_req = "R2/R3 pwm";     run(400, 16, PER);
    cur_req = "R5 duty cap";   run(300, PER, PER);
    cur_req = "R6 zero current"; run(320, 10, 28);
    cur_req = "R7 skip";       run(200, 0, PER);
    check("R7", "skip after idle periods", skip_ind, 1);
    run(2 * PER, 12, PER);
    check("R7", "skip after active period", skip_ind, 0);
    cur_req = "R4 timeout"; stuck = 1; run(240, 14, PER); stuck = 0;
    cur_req = "R9 force low"; force_ls = 1; run(200, 20, 0);
    check("R9", "ls held by force", ls_gate, 1);
    check("R9", "hs blocked by force", hs_gate, 0);
    force_ls = 0;
    cur_req = "R8 disable"; en = 0; run(20, 20, PER);
    check("R8", "hs off while disabled", hs_gate, 0);
    check("R8", "ls off while disabled", ls_gate, 0);
    check("R8", "skip off while disabled", skip_ind, 0);
    en = 1; cur_req = "R8 restart"; run(200, 18, 30);
    compare_on = 0; finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule